// File: doc/BRIEF.md
# Stretch-Aware I2C Master SCL Generator

This block produces the SCL line for an I2C master from a fast system clock. A half-bit pacing counter fires one decision tick per half-bit. Each tick moves a phase machine that either pulls SCL low or lets it go. When the master has let SCL go but the synchronised line still reads low, the pacing counter is frozen, so long as the current phase is one in which the hold applies. The line may read low because it is still rising or because a target is stretching the clock. Once the line is seen high, the counter runs a full half-period. A late release by the target therefore cannot yield a runt high pulse.

A byte engine starts a transfer with `start_req` and ends it with `stop_req`. It follows the clock through one-cycle strobes that mark the cycle SCL is pulled low and the cycle it is let go. SDA, byte shifting and arbitration stay with that engine. The machine has six states:
- `ST_IDLE`: SCL released, counter cleared.
- `ST_START`: one extra high half-bit for start hold.
- `ST_LOW`: SCL driven low.
- `ST_HIGH`: SCL released for a bit.
- `ST_STOP1`: stop high half-bit.
- `ST_STOP2`: extra high half-bit after the stop.

The transitions are:
- IDLE→START on an accepted start.
- START→LOW on a tick.
- LOW→HIGH on a tick.
- HIGH→LOW on a tick.
- LOW→STOP1 on a tick while a stop is pending.
- STOP1→STOP2 on a tick.
- STOP2→IDLE on a tick.
- Any state→IDLE when `en` is low or the stretch timeout expires.

Top module: `scl_stretch_gen`

## Requirements
- R1: After reset `scl_oe`, `busy`, `rise_stb`, `fall_stb` and `tout_err` are all 0.
- R2: With `en` high in idle, a `start_req` seen at a clock edge makes `busy` 1 from that edge. SCL then stays released for exactly D cycles before it is first driven low. D is the latched divide value.
- R3: Every low half-bit (`scl_oe`=1) lasts exactly D cycles, stretching or not.
- R4: With `hold_every_high`=1, every released bit half-bit keeps the sensed line high for exactly D+2 cycles, whatever the target stretch length. The 2 cycles are the input synchroniser latency.
- R5: With `hold_every_high`=0, only the ninth released half-bit of each byte is held. This is the acknowledge bit, index 8 when counted from 0 after start, and it repeats for every byte. That half-bit gives D+2 high cycles and the other eight give D.
- R6: While the pacing counter is frozen (the master has released SCL in a held phase and the synchronised line reads low) the machine does not advance.
- R7: `fall_stb` is 1 for exactly the first cycle of each low half-bit. `rise_stb` is 1 for exactly the first cycle after each low half-bit that is followed by a released phase. The two strobes are never 1 together.
- R8: A `stop_req` while busy is honoured at the end of the next low half-bit, followed by two released half-bits and then idle. The sensed high time from release to idle is 2D+2 cycles with `hold_every_high`=1 and 2D cycles with 0.
- R9: If a held phase stays frozen for `tout_halves`×D cycles, the block goes idle and `tout_err` becomes 1. It clears when the next start is accepted. `tout_halves`=0 disables the timeout.
- R10: `div_val` is latched only in idle. Values 0 and 1 act as 2. Changes while busy have no effect on half-bit lengths.
- R11: `en` low sends the block to idle at the next edge with SCL released, and `start_req` is ignored while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low aborts to idle |
| hold_every_high | input | 1 | 1: freeze on every released phase; 0: only on acknowledge bits |
| div_val | input | DIV_W | Cycles per half-bit, latched in idle |
| tout_halves | input | TO_W | Stretch limit in half-bits; 0 disables |
| start_req | input | 1 | Request a start from idle |
| stop_req | input | 1 | Request a stop while busy |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| rise_stb | output | 1 | One-cycle strobe at SCL release |
| fall_stb | output | 1 | One-cycle strobe at SCL pull-down |
| busy | output | 1 | Not idle |
| tout_err | output | 1 | Stretch timeout occurred |

## Verification
The line model adds target stretching of random length on top of the master's drive. The same runs are repeated in both hold modes with random divide values, including 0 and 1. Exact high-time counts separate a frozen counter (always D+2) from a free-running one (a runt whose width shrinks with the stretch), and separate acknowledge-only holding from holding on every bit. Directed cases cover start length, both stop lengths, the timeout expiry count and error clearing, an enable abort, and divider changes in mid-transfer.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STOP1,
        ST_STOP2
    } scl_phase_e;

    localparam int unsigned ACK_BIT_IDX = 8;
    localparam int unsigned MIN_DIV     = 2;
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '1;
                else        shreg <= d_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '1;
                else        shreg <= {shreg[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = shreg[STAGES-1];
endmodule

// File: rtl/scl_half_pacer.sv
module scl_half_pacer #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             freeze,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = !restart && !freeze && (cnt == div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (freeze)  cnt <= cnt;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/scl_stretch_watch.sv
module scl_stretch_watch #(
    parameter int unsigned DIV_W = 12,
    parameter int unsigned TO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen,
    input  logic [DIV_W-1:0] div,
    input  logic [TO_W-1:0]  limit,
    output logic             expired
);
    logic [DIV_W-1:0] cyc;
    logic [TO_W-1:0]  halves;
    logic             half_done;

    assign half_done = (cyc == div - DIV_W'(1));
    assign expired   = frozen && (limit != '0) && half_done &&
                       (halves == limit - TO_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc    <= '0;
            halves <= '0;
        end else if (!frozen) begin
            cyc    <= '0;
            halves <= '0;
        end else if (half_done) begin
            cyc    <= '0;
            halves <= halves + TO_W'(1);
        end else begin
            cyc    <= cyc + DIV_W'(1);
        end
    end
endmodule

// File: rtl/scl_stretch_gen.sv
module scl_stretch_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned DIV_W       = 12,
    parameter int unsigned TO_W        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold_every_high,
    input  logic [DIV_W-1:0] div_val,
    input  logic [TO_W-1:0]  tout_halves,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             busy,
    output logic             tout_err
);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);
    localparam logic [3:0]       ACK_IDX   = 4'(ACK_BIT_IDX);

    scl_phase_e       st, st_nx;
    logic [DIV_W-1:0] div_q, div_eff;
    logic [3:0]       bitn;
    logic             stop_pend;
    logic             scl_s;
    logic             released, hold_phase, frozen;
    logic             tick, expired;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s)
    );

    assign released   = (st == ST_START) || (st == ST_HIGH) ||
                        (st == ST_STOP1) || (st == ST_STOP2);
    assign hold_phase = hold_every_high ? released
                                        : ((st == ST_HIGH) && (bitn == ACK_IDX));
    assign frozen     = hold_phase && !scl_s;
    assign div_eff    = (div_val < DIV_FLOOR) ? DIV_FLOOR : div_val;

    scl_half_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .restart(st == ST_IDLE),
        .freeze(frozen), .div(div_q), .tick(tick)
    );

    scl_stretch_watch #(.DIV_W(DIV_W), .TO_W(TO_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .frozen(frozen), .div(div_q),
        .limit(tout_halves), .expired(expired)
    );

    // next-phase decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (en && start_req) st_nx = ST_START;
            ST_START: if (tick) st_nx = ST_LOW;
            ST_LOW:   if (tick) st_nx = (stop_pend || stop_req) ? ST_STOP1 : ST_HIGH;
            ST_HIGH:  if (tick) st_nx = ST_LOW;
            ST_STOP1: if (tick) st_nx = ST_STOP2;
            ST_STOP2: if (tick) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
        if (!en || expired) st_nx = ST_IDLE;
    end

    // phase register and per-phase bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            div_q     <= DIV_FLOOR;
            bitn      <= '0;
            stop_pend <= 1'b0;
            tout_err  <= 1'b0;
            rise_stb  <= 1'b0;
            fall_stb  <= 1'b0;
        end else begin
            st       <= st_nx;
            fall_stb <= (st_nx == ST_LOW) && (st != ST_LOW);
            rise_stb <= (st == ST_LOW) && (st_nx != ST_LOW) && (st_nx != ST_IDLE);
            if (st == ST_IDLE) div_q <= div_eff;
            if (st_nx == ST_START) begin
                bitn     <= '0;
                tout_err <= 1'b0;
            end else if ((st == ST_HIGH) && (st_nx == ST_LOW)) begin
                bitn <= (bitn == ACK_IDX) ? '0 : bitn + 4'd1;
            end
            if (expired) tout_err <= 1'b1;
            if ((st_nx == ST_STOP1) || (st_nx == ST_IDLE)) stop_pend <= 1'b0;
            else if (stop_req && (st != ST_IDLE))          stop_pend <= 1'b1;
        end
    end

    // pin outputs
    always_comb begin
        scl_oe = (st == ST_LOW);
        busy   = (st != ST_IDLE);
    end
endmodule

// File: rtl/scl_stretch_gen_chk.sv
module scl_stretch_gen_chk #(
    parameter int unsigned TO_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            hold_every_high,
    input logic [TO_W-1:0] tout_halves,
    input logic            scl_oe,
    input logic            rise_stb,
    input logic            fall_stb,
    input logic            busy,
    input logic            tout_err,
    input logic            sync_lvl
);
    p_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    p_fall_marks_pulldown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (scl_oe && !$past(scl_oe)));

    p_rise_marks_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (!scl_oe && $past(scl_oe)));

    p_frozen_no_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hold_every_high && busy && !scl_oe && !sync_lvl && (tout_halves == '0))
        |=> (busy && !scl_oe));

    p_error_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tout_err |-> !busy);

    p_disable_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
endmodule

bind scl_stretch_gen scl_stretch_gen_chk #(.TO_W(TO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .hold_every_high(hold_every_high),
    .tout_halves(tout_halves), .scl_oe(scl_oe), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .busy(busy), .tout_err(tout_err), .sync_lvl(scl_s)
);

// File: tb/tb_scl_stretch_gen.sv
module tb_scl_stretch_gen;
    localparam int DIV_W = 12;
    localparam int TO_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic hold_every_high = 1'b1;
    logic [DIV_W-1:0] div_val = '0;
    logic [TO_W-1:0]  tout_halves = '0;
    logic start_req = 1'b0, stop_req = 1'b0;
    logic scl_oe, rise_stb, fall_stb, busy, tout_err;
    logic tgt_hold = 1'b0, tgt_force = 1'b0;
    logic scl_line;

    assign scl_line = !(scl_oe || tgt_hold || tgt_force);

    scl_stretch_gen #(.DIV_W(DIV_W), .TO_W(TO_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .hold_every_high(hold_every_high),
        .div_val(div_val), .tout_halves(tout_halves), .start_req(start_req),
        .stop_req(stop_req), .scl_in(scl_line), .scl_oe(scl_oe),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .busy(busy), .tout_err(tout_err)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int cur_d = 2;
    bit mode_all = 1'b1;
    bit stretch_en = 1'b0;
    int stretch_max = 15;
    int hidx = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff_div(input int d);
        return (d < 2) ? 2 : d;
    endfunction

    function automatic int exp_high(input int d, input bit all, input int idx);
        return (all || idx == 8) ? d + 2 : d;
    endfunction

    // line monitor: half-bit lengths and strobes
    bit prev_oe = 1'b0, prev_busy = 1'b0, in_high = 1'b0;
    int lowrun = 0, hirun = 0, exp_hi = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (busy && !prev_busy) begin hidx = 0; in_high = 0; lowrun = 0; end
            if (!busy) begin in_high = 0; lowrun = 0; end
            chk(fall_stb == (scl_oe && !prev_oe), "R7 fall strobe", fall_stb, scl_oe && !prev_oe);
            chk(rise_stb == (!scl_oe && prev_oe && busy), "R7 rise strobe", rise_stb, !scl_oe && prev_oe && busy);
            if (scl_oe) begin
                if (!prev_oe && in_high) begin
                    chk(hirun == exp_hi, mode_all ? "R4 held high length" : "R5 ack-only high length", hirun, exp_hi);
                    hidx = (hidx == 8) ? 0 : hidx + 1;
                    in_high = 0;
                end
                lowrun++;
            end else if (prev_oe && busy) begin
                chk(lowrun == cur_d, "R3/R10 low length", lowrun, cur_d);
                lowrun = 0;
                in_high = 1;
                hirun = 0;
                exp_hi = exp_high(cur_d, mode_all, hidx);
            end
            if (in_high && scl_line) hirun++;
            prev_oe = scl_oe;
            prev_busy = busy;
        end
    end

    // target model: stretches SCL after the master releases it
    initial begin
        bit prev_t = 1'b0, decided = 1'b0;
        int rem = 0;
        forever begin
            @(posedge clk); #1;
            if (!busy) begin
                tgt_hold = 1'b0; decided = 1'b0;
            end else if (scl_oe) begin
                if (prev_t && !decided) begin
                    decided = 1'b1;
                    if (stretch_en && (mode_all || hidx == 8)) begin
                        rem = $urandom_range(0, stretch_max);
                        if (rem > 0) tgt_hold = 1'b1;
                    end
                end
            end else begin
                decided = 1'b0;
                if (tgt_hold) begin
                    rem--;
                    if (rem <= 0) tgt_hold = 1'b0;
                end
            end
            prev_t = scl_oe;
        end
    end

    task automatic launch(input int d, input bit all);
        @(negedge clk);
        div_val = DIV_W'(d);
        hold_every_high = all;
        mode_all = all;
        cur_d = eff_div(d);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!rise_stb);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic stop_and_measure(input int d, input bit all);
        int cnt;
        launch(d, all);
        wait_rise();
        wait_rise();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wait_rise();
        cnt = 0;
        while (busy) begin
            if (scl_line) cnt++;
            @(negedge clk);
        end
        chk(cnt == (all ? 2 * d + 2 : 2 * d), "R8 stop high time", cnt, all ? 2 * d + 2 : 2 * d);
    endtask

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !busy && !rise_stb && !fall_stb && !tout_err, "R1 reset state",
            {scl_oe, busy, rise_stb, fall_stb, tout_err}, 0);

        // R11: start ignored with enable low
        en = 1'b0;
        start_req = 1'b1;
        repeat (3) @(negedge clk);
        start_req = 1'b0;
        chk(!busy, "R11 start ignored when disabled", busy, 0);
        en = 1'b1;

        // R2: start half-bit length
        launch(3, 1'b1);
        cnt = 0;
        chk(busy, "R2 busy after start", busy, 1);
        while (busy && !scl_oe) begin cnt++; @(negedge clk); end
        chk(cnt == 3, "R2 start high length", cnt, 3);
        wait_rise();
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        wait_idle();

        // R8: stop in both modes
        stop_and_measure(4, 1'b1);
        stop_and_measure(4, 1'b0);

        // R10: minimum divide, monitor expects 2
        launch(1, 1'b1);
        repeat (6) wait_rise();
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        wait_idle();

        // R11: abort mid-transfer
        launch(5, 1'b1);
        wait_rise();
        repeat (2) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!busy && !scl_oe, "R11 abort to idle", {busy, scl_oe}, 0);
        en = 1'b1;
        @(negedge clk);

        // R9: stretch timeout
        tout_halves = TO_W'(4);
        launch(3, 1'b1);
        do @(negedge clk); while (!fall_stb);
        tgt_force = 1'b1;
        wait_rise();
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk(cnt == 12, "R9 timeout after limit", cnt, 12);
        chk(tout_err, "R9 error flag set", tout_err, 1);
        tgt_force = 1'b0;
        repeat (3) @(negedge clk);
        chk(tout_err, "R9 error flag holds in idle", tout_err, 1);
        tout_halves = '0;
        launch(3, 1'b1);
        chk(!tout_err, "R9 error cleared by start", tout_err, 1'b0);
        wait_rise();
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        wait_idle();

        // random transfers with stretching and mid-run divider changes
        stretch_en = 1'b1;
        for (int r = 0; r < 24; r++) begin
            int d = $urandom_range(0, 9);
            bit all = 1'($urandom_range(0, 1));
            launch(d, all);
            repeat ($urandom_range(5, 30)) wait_rise();
            div_val = DIV_W'($urandom_range(0, 15)); // R10: ignored while busy
            repeat (2) wait_rise();
            stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
            wait_idle();
            chk(!tout_err, "R9 disabled timeout never fires", tout_err, 0);
        end
        stretch_en = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule